// File: doc/BRIEF.md
# Multi-core interrupt distribution unit

This block lets processor cores interrupt one another through a set of shared interrupt lines. Each shared line has a target-core bitmask and a mode word. Raising a line interrupts every core that the line's routing selects. Every core keeps its own pending and acknowledge state for every line. The output bus has one wire per core per line. Wire `core*NUM_LINES + line` feeds that core's local interrupt input `16 + line`.

Software never addresses the per-line state directly. First it writes an operand into the parameter register. Then it writes a command word that names an operation and a line number. Queries return their answer through the same parameter register, which can be read one cycle later. Global enable and disable commands gate all delivery. The usual flow is to disable the unit, set up the lines, and enable it again.

Top module: `irq_distributor`

## Requirements
- R1: After reset all outputs are 0, the parameter register reads 0, the unit is disabled, and every bitmask, mode, pending bit and acknowledge bit is 0.
- R2: A write with `wr_sel`=0 loads `wr_data` into the parameter register, which `param_rd` shows from the next cycle. A write with `wr_sel`=1 is a command: opcode in bits 15:8, line number in bits 4:0. The opcodes are 0x01 enable, 0x02 disable, 0x03 write mode, 0x04 write bitmask, 0x05 assert, 0x06 clear, 0x07 query pending and 0x08 query acknowledge.
- R3: Write-bitmask loads parameter bits NUM_CORES-1:0 as the line's targets, where bit n selects core n. Write-mode loads the destination mode from parameter bits 2:0 and the trigger mode from bit 4, where 1 means pulse. In pulse mode with destination mode 7, an assert on an enabled unit gives every targeted core a strobe of exactly one cycle, in the cycle after the command.
- R4: Any destination mode other than 7 sends an assert only to the lowest-numbered core in the line's bitmask.
- R5: In level mode (trigger bit 0), a core's output stays high while that core's pending bit is set and the unit is enabled.
- R6: Query-pending places the line's per-core pending bitmask in `param_rd` bits NUM_CORES-1:0 in the next cycle, with all upper bits 0.
- R7: Assert sets pending and clears acknowledge for each selected core. Clear, issued by the core on `wr_core`, clears that core's pending bit and sets its acknowledge bit only if the pending bit was set.
- R8: Query-acknowledge places the line's per-core acknowledge bitmask in `param_rd` in the next cycle, with all upper bits 0.
- R9: While disabled, no output is raised, but an assert still records pending. Enable on a disabled unit strobes once every pending core on pulse-mode lines. Enable on an already enabled unit strobes nothing.
- R10: A per-line command whose line number is NUM_LINES or more, and any command with an unlisted opcode, changes no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the parameter register, 1 selects the command register |
| wr_core | input | CORE_W | Index of the core issuing the write, used by clear |
| wr_data | input | DATA_W | Write data |
| param_rd | output | DATA_W | Parameter register contents |
| core_irq | output | NUM_CORES*NUM_LINES | Interrupt outputs, bit core*NUM_LINES+line |

## Verification
Every result is registered on the rising edge that samples the write, and is due in the cycle right after it. This applies to strobes, level outputs, query answers and parameter loads. The bench drives each write at a falling edge and compares all outputs with its own model at the next falling edge. It then issues the next write at once, so a run of back-to-back commands is checked one cycle at a time. Idle steps check that pulse strobes have dropped after one cycle while level outputs stay up.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NUM_LINES = 16,
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           wr_sel,
  input  logic [CORE_W-1:0]              wr_core,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [DATA_W-1:0]              param_rd,
  output logic [NUM_CORES*NUM_LINES-1:0] core_irq
);
  localparam int LIDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [7:0] OP_ENA = 8'h01, OP_DIS = 8'h02, OP_MODE = 8'h03, OP_MASK = 8'h04,
                         OP_SET = 8'h05, OP_CLR = 8'h06, OP_QPND = 8'h07, OP_QACK = 8'h08;
  localparam logic [2:0] DEST_ALL = 3'd7;

  logic [NUM_CORES-1:0] mask_q [NUM_LINES];
  logic [NUM_CORES-1:0] pend_q [NUM_LINES];
  logic [NUM_CORES-1:0] ack_q  [NUM_LINES];
  logic [NUM_CORES-1:0] strb_q [NUM_LINES];
  logic [2:0]           dest_q [NUM_LINES];
  logic [NUM_LINES-1:0] trig_q;
  logic                 en_q;
  logic [DATA_W-1:0]    param_q;

  wire [7:0]        op      = wr_data[15:8];
  wire [4:0]        line    = wr_data[4:0];
  wire [LIDX_W-1:0] lidx    = line[LIDX_W-1:0];
  wire              cmd     = wr_en && wr_sel;
  wire              line_ok = 32'(line) < NUM_LINES;

  wire [NUM_CORES-1:0] sel = mask_q[lidx];
  wire [NUM_CORES-1:0] tgt = (dest_q[lidx] == DEST_ALL) ? sel : (sel & (~sel + NUM_CORES'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      param_q <= '0;
      trig_q  <= '0;
      for (int l = 0; l < NUM_LINES; l++) begin
        mask_q[l] <= '0;
        pend_q[l] <= '0;
        ack_q[l]  <= '0;
        strb_q[l] <= '0;
        dest_q[l] <= '0;
      end
    end else begin
      for (int l = 0; l < NUM_LINES; l++) strb_q[l] <= '0;
      if (wr_en && !wr_sel) param_q <= wr_data;
      if (cmd && op == OP_ENA) begin
        en_q <= 1'b1;
        if (!en_q)
          for (int l = 0; l < NUM_LINES; l++) strb_q[l] <= pend_q[l] & {NUM_CORES{trig_q[l]}};
      end
      if (cmd && op == OP_DIS) en_q <= 1'b0;
      if (cmd && line_ok) begin
        case (op)
          OP_MODE: begin
            dest_q[lidx] <= param_q[2:0];
            trig_q[lidx] <= param_q[4];
          end
          OP_MASK: mask_q[lidx] <= param_q[NUM_CORES-1:0];
          OP_SET: begin
            pend_q[lidx] <= pend_q[lidx] | tgt;
            ack_q[lidx]  <= ack_q[lidx] & ~tgt;
            if (en_q && trig_q[lidx]) strb_q[lidx] <= tgt;
          end
          OP_CLR: begin
            pend_q[lidx][wr_core] <= 1'b0;
            if (pend_q[lidx][wr_core]) ack_q[lidx][wr_core] <= 1'b1;
          end
          OP_QPND: param_q <= DATA_W'(pend_q[lidx]);
          OP_QACK: param_q <= DATA_W'(ack_q[lidx]);
          default: ;
        endcase
      end
    end
  end

  assign param_rd = param_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      assign core_irq[c*NUM_LINES+l] = strb_q[l][c] | (en_q & ~trig_q[l] & pend_q[l][c]);
    end
  end
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
  parameter int NUM_LINES = 16,
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic                           wr_sel,
  input logic [DATA_W-1:0]              wr_data,
  input logic [DATA_W-1:0]              param_rd,
  input logic [NUM_CORES*NUM_LINES-1:0] core_irq,
  input logic                           en_q,
  input logic [NUM_LINES-1:0]           trig_q
);
  wire cmd     = wr_en && wr_sel;
  wire is_qry  = (wr_data[15:8] == 8'h07) || (wr_data[15:8] == 8'h08);
  wire line_ok = 32'(wr_data[4:0]) < NUM_LINES;

  // R9: nothing is delivered while the unit is disabled
  a_r9_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> core_irq == '0);

  // R2: the parameter register changes only on a write
  a_r2_param_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(param_rd));

  // R6, R8: query answers carry no bits above the core count
  a_r6_query_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && is_qry && line_ok) |=> param_rd[DATA_W-1:NUM_CORES] == '0);

  // R10: a query on a line beyond the range leaves the parameter register alone
  a_r10_bad_line_query: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && is_qry && !line_ok) |=> $stable(param_rd));

  // R3: a pulse-mode strobe lasts one cycle unless a new command follows
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_l
      a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq[c*NUM_LINES+l] && trig_q[l]) |=> (!core_irq[c*NUM_LINES+l] || $past(cmd)));
    end
  end
endmodule

bind irq_distributor irq_distributor_chk #(
  .NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .param_rd(param_rd), .core_irq(core_irq), .en_q(en_q), .trig_q(trig_q)
);

// File: tb/tb_irq_distributor.sv
`timescale 1ns/1ps
module tb_irq_distributor;
  localparam int L = 16, C = 4, W = 32;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [1:0] wr_core = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] param_rd;
  logic [C*L-1:0] core_irq;

  always #4 clk = ~clk;

  irq_distributor #(.NUM_LINES(L), .NUM_CORES(C), .DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_core(wr_core),
    .wr_data(wr_data), .param_rd(param_rd), .core_irq(core_irq));

  int checks = 0, fails = 0;
  bit [C-1:0] m_mask [L], m_pend [L], m_ack [L], m_strb [L];
  bit [2:0] m_dest [L];
  bit m_trig [L];
  bit m_en;
  bit [W-1:0] m_param;

  function automatic bit [C*L-1:0] exp_irq();
    bit [C*L-1:0] v = '0;
    for (int c = 0; c < C; c++)
      for (int l = 0; l < L; l++)
        v[c*L+l] = m_strb[l][c] | (m_en & !m_trig[l] & m_pend[l][c]);
    return v;
  endfunction

  function automatic bit [C-1:0] route(int l);
    if (m_dest[l] == 3'd7) return m_mask[l];
    for (int c = 0; c < C; c++) if (m_mask[l][c]) return C'(1) << c;
    return '0;
  endfunction

  function automatic string tag_of(bit [7:0] op);
    case (op)
      8'h01, 8'h02: return "R9";
      8'h03, 8'h04: return "R3";
      8'h05, 8'h06: return "R7";
      8'h07: return "R6";
      8'h08: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic compare(string tag);
    checks++;
    if (core_irq !== exp_irq()) begin
      fails++;
      $display("FAIL %s core_irq actual %h expected %h", tag, core_irq, exp_irq());
    end
    checks++;
    if (param_rd !== m_param) begin
      fails++;
      $display("FAIL %s param_rd actual %h expected %h", tag, param_rd, m_param);
    end
  endtask

  task automatic wr_par(bit [W-1:0] v, string tag);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = v;
    @(posedge clk);
    for (int l = 0; l < L; l++) m_strb[l] = '0;
    m_param = v;
    @(negedge clk);
    wr_en = 1'b0;
    compare(tag);
  endtask

  task automatic do_cmd(bit [7:0] op, bit [4:0] line, bit [1:0] core, string tag);
    bit [C-1:0] t;
    wr_en = 1'b1; wr_sel = 1'b1; wr_core = core;
    wr_data = {16'd0, op, 3'd0, line};
    @(posedge clk);
    for (int l = 0; l < L; l++) m_strb[l] = '0;
    if (op == 8'h01) begin
      if (!m_en) for (int l = 0; l < L; l++) m_strb[l] = m_trig[l] ? m_pend[l] : '0;
      m_en = 1'b1;
    end else if (op == 8'h02) m_en = 1'b0;
    else if (line < L) begin
      case (op)
        8'h03: begin m_dest[line] = m_param[2:0]; m_trig[line] = m_param[4]; end
        8'h04: m_mask[line] = m_param[C-1:0];
        8'h05: begin
          t = route(line);
          m_pend[line] |= t;
          m_ack[line] &= ~t;
          if (m_en && m_trig[line]) m_strb[line] = t;
        end
        8'h06: begin
          if (m_pend[line][core]) m_ack[line][core] = 1'b1;
          m_pend[line][core] = 1'b0;
        end
        8'h07: m_param = W'(m_pend[line]);
        8'h08: m_param = W'(m_ack[line]);
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    compare(tag);
  endtask

  task automatic idle(string tag);
    @(posedge clk);
    for (int l = 0; l < L; l++) m_strb[l] = '0;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL all watchdog expired actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int l = 0; l < L; l++) begin
      m_mask[l] = '0; m_pend[l] = '0; m_ack[l] = '0; m_strb[l] = '0;
      m_dest[l] = '0; m_trig[l] = 1'b0;
    end
    m_en = 1'b0; m_param = '0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    do_cmd(8'h07, 5'd3, 2'd0, "R1 pending zero");
    do_cmd(8'h08, 5'd3, 2'd0, "R1 ack zero");
    wr_par(32'hA5A5_0001, "R2 param load");

    wr_par(32'h0000_000B, "R3 mask operand");
    do_cmd(8'h04, 5'd2, 2'd0, "R3 write mask");
    wr_par(32'h0000_0017, "R3 mode operand");
    do_cmd(8'h03, 5'd2, 2'd0, "R3 write mode");
    do_cmd(8'h01, 5'd0, 2'd0, "R9 enable");
    do_cmd(8'h05, 5'd2, 2'd0, "R3 pulse to all targets");
    idle("R3 strobe gone");
    do_cmd(8'h07, 5'd2, 2'd0, "R6 pending bitmask");
    do_cmd(8'h06, 5'd2, 2'd1, "R7 clear by core1");
    do_cmd(8'h08, 5'd2, 2'd0, "R8 ack bitmask");
    do_cmd(8'h06, 5'd2, 2'd2, "R7 clear not pending");
    do_cmd(8'h08, 5'd2, 2'd0, "R8 ack unchanged");
    do_cmd(8'h05, 5'd2, 2'd0, "R7 assert clears ack");
    do_cmd(8'h08, 5'd2, 2'd0, "R7 ack cleared");

    wr_par(32'h0000_000C, "R4 mask operand");
    do_cmd(8'h04, 5'd5, 2'd0, "R4 write mask");
    wr_par(32'h0000_0010, "R4 mode operand");
    do_cmd(8'h03, 5'd5, 2'd0, "R4 write mode");
    do_cmd(8'h05, 5'd5, 2'd0, "R4 lowest core only");

    wr_par(32'h0000_0001, "R5 mask operand");
    do_cmd(8'h04, 5'd7, 2'd0, "R5 write mask");
    wr_par(32'h0000_0007, "R5 mode operand");
    do_cmd(8'h03, 5'd7, 2'd0, "R5 write mode");
    do_cmd(8'h05, 5'd7, 2'd0, "R5 level raised");
    idle("R5 level held");
    idle("R5 level held");
    do_cmd(8'h06, 5'd7, 2'd0, "R5 level dropped");

    do_cmd(8'h02, 5'd0, 2'd0, "R9 disable");
    do_cmd(8'h05, 5'd2, 2'd0, "R9 assert while off");
    do_cmd(8'h05, 5'd7, 2'd0, "R9 level while off");
    idle("R9 still silent");
    do_cmd(8'h01, 5'd0, 2'd0, "R9 enable replays");
    idle("R9 replay single");
    do_cmd(8'h01, 5'd0, 2'd0, "R9 enable no replay");

    do_cmd(8'h07, 5'd20, 2'd0, "R10 query out of range");
    do_cmd(8'h05, 5'd16, 2'd0, "R10 assert out of range");
    do_cmd(8'h0F, 5'd2, 2'd0, "R10 unknown opcode");
    do_cmd(8'h07, 5'd2, 2'd0, "R10 state intact");

    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom % 20;
      bit [7:0] op;
      if (r < 3) begin
        wr_par(($urandom % 3 == 0) ? ($urandom & 32'h17) : $urandom, "R2 random operand");
        continue;
      end
      if (r < 4) op = ($urandom % 4 == 0) ? 8'h02 : 8'h01;
      else if (r < 5) op = 8'h0F;
      else if (r < 6) begin idle("R3 random idle"); continue; end
      else op = 8'(3 + $urandom % 6);
      do_cmd(op, 5'($urandom % 18), 2'($urandom), tag_of(op));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule